// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a slave on a two-wire serial bus (clock and data, both open-drain) that serves byte reads out of a memory held outside it. It holds an address counter of `AW` bits that drives a combinational memory read port. The bus lines arrive as plain inputs. The slave pulls data low by raising `sda_oe`, so the pad drives the line low when the enable is high.

A master points the counter at a location with a write-mode address phase. This phase carries the device byte and then two word-address bytes. The master then either issues a repeated START and reads, or issues a STOP so that the counter is only loaded. Reads go out most significant bit first from the counter. Each master acknowledge moves the counter forward by one and sends the next byte, and the counter wraps from the top of the space back to zero. A not-acknowledge, or a STOP in the acknowledge slot, ends the read. After a STOP or an address mismatch the slave ignores the bus until it sees a new START. Both bus lines are synchronised with two flops before edges are taken on the system clock.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset `sda_oe` is 0 and `mem_addr` is 0.
- R2: START (data falling while clock high) is honoured in any state, including part way through a byte, and restarts reception of the device byte. STOP is data rising while clock high.
- R3: The slave acknowledges a device byte whose upper seven bits equal `DEV_ADDR`, with bit 0 as the read flag (1 = read). On a mismatch it gives no acknowledge and ignores every later bit until the next START.
- R4: With the read flag at 0, the slave acknowledges two word-address bytes, high byte first. Once the second byte is in, the counter takes the low `AW` bits of {high, low}, so high-byte bits at and above position `AW-8` are ignored. The counter keeps this value even when a STOP follows, and no data is returned in that case.
- R5: With the read flag at 1, the slave drives one byte MSB first from `mem_rdata` at the counter address. The byte begins right after the acknowledge slot.
- R6: A master acknowledge (data low on the ninth clock of a read byte) adds 1 to the counter and starts the byte at the new address.
- R7: The counter wraps from 2^AW-1 to 0 during sequential reads.
- R8: Data high on the ninth clock, or a STOP in that slot, ends the read. The counter keeps the address of the last byte sent, so the next current-address read repeats it.
- R9: After a STOP the slave drives nothing and does not respond to clocked bits until a START.
- R10: `sda_oe` changes only while the clock is low, and it is high only in acknowledge slots and on zero-valued read data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | AW | Counter address for the memory read port |
| mem_rdata | input | 8 | Byte at `mem_addr`, combinational |

## Verification
The assertions assume that each bus clock phase lasts well beyond the three-flop synchroniser delay. They also assume that the master moves the data line only while the clock is low, except when it makes a START or STOP. They further assume that `mem_rdata` follows `mem_addr` in the same cycle. The bench's master holds every clock phase for 20 to 40 system cycles and changes its data line mid-way through the low phase. Its memory model is a combinational function of the address.

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  localparam logic [3:0] S_IDLE = 4'd0, S_DEV = 4'd1, S_DACK = 4'd2, S_WA1 = 4'd3,
                         S_A1ACK = 4'd4, S_WA0 = 4'd5, S_A0ACK = 4'd6, S_HOLD = 4'd7,
                         S_RD = 4'd8, S_RACK = 4'd9;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [3:0] st, bcnt;
  logic [7:0] shr, hi_byte;
  logic rw, mack, rx_state;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rx_state  = (st == S_DEV) || (st == S_WA1) || (st == S_WA0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; shr <= '0; hi_byte <= '0;
      rw <= 1'b0; mack <= 1'b0; cnt <= '0;
    end else if (start_det) begin
      st <= S_DEV; bcnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE; bcnt <= '0;
    end else begin
      if (scl_rise) begin
        if (rx_state) begin
          shr  <= {shr[6:0], sda_s};
          bcnt <= bcnt + 4'd1;
        end
        if (st == S_RACK) mack <= ~sda_s;
      end
      if (scl_fall)
        case (st)
          S_DEV:
            if (bcnt == 4'd8) begin
              bcnt <= '0;
              if (shr[7:1] == DEV_ADDR) begin
                rw <= shr[0]; st <= S_DACK;
              end else st <= S_IDLE;
            end
          S_DACK:  st <= rw ? S_RD : S_WA1;
          S_WA1:
            if (bcnt == 4'd8) begin
              hi_byte <= shr; bcnt <= '0; st <= S_A1ACK;
            end
          S_A1ACK: st <= S_WA0;
          S_WA0:
            if (bcnt == 4'd8) begin
              cnt <= AW'({hi_byte, shr}); bcnt <= '0; st <= S_A0ACK;
            end
          S_A0ACK: st <= S_HOLD;
          S_RD:
            if (bcnt == 4'd7) begin
              bcnt <= '0; st <= S_RACK;
            end else bcnt <= bcnt + 4'd1;
          S_RACK:
            if (mack) begin
              cnt <= cnt + AW'(1); st <= S_RD;
            end else st <= S_IDLE;
          default: ;
        endcase
    end

  assign mem_addr = cnt;
  assign sda_oe   = (st == S_DACK) || (st == S_A1ACK) || (st == S_A0ACK) ||
                    ((st == S_RD) && !mem_rdata[3'd7 - bcnt[2:0]]);
endmodule

module i2c_mem_reader_chk #(parameter int AW = 11) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    st,
  input logic          start_det,
  input logic          stop_det
);
  localparam logic [3:0] C_IDLE = 4'd0, C_DEV = 4'd1, C_WA0 = 4'd5, C_RD = 4'd8, C_RACK = 4'd9;

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  a_r2_start_enters_dev: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> st == C_DEV);
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> (st == C_IDLE && !sda_oe));
  a_r4_addr_moves_on_load_or_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> ($past(st) == C_WA0 || $past(st) == C_RACK));
  a_r6_step_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_RACK && st == C_RD) |-> mem_addr == AW'($past(mem_addr) + 1'b1));
endmodule

bind i2c_mem_reader i2c_mem_reader_chk #(.AW(AW)) chk_i (.*);

// File: tb/i2c_mem_reader_tb_top.sv
module i2c_mem_reader_tb_top;
  localparam logic [6:0] DEV = 7'h50;
  localparam int AW = 11;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, failures = 0, viol = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_val;
  event rx_ev;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_f(mem_addr);

  i2c_mem_reader #(.DEV_ADDR(DEV), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10); sda_m = 1'b0; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(10); scl = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(10); scl = 1'b1; tick(20); scl = 1'b0; tick(10);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10); ack = !sda_bus; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic wb_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    wb(b, a);
    chk(a == exp_ack, req, "acknowledge", a, exp_ack);
  endtask

  task automatic get_bits(output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(10); scl = 1'b1; tick(10); v[i] = sda_bus; tick(10); scl = 1'b0; tick(10);
    end
    rx_val = v;
    -> rx_ev;
  endtask

  task automatic rb(input logic ack);
    logic [7:0] v;
    get_bits(v);
    sda_m = ~ack; tick(10); scl = 1'b1; tick(20); scl = 1'b0; tick(10); sda_m = 1'b1;
  endtask

  task automatic rb_stop_in_ack();
    logic [7:0] v;
    get_bits(v);
    sda_m = 1'b0; tick(10); scl = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic expect_byte(input logic [AW-1:0] a, input string tag);
    exp_q.push_back(mem_f(a));
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected byte", rx_val, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rx_val == e, t, "read byte", rx_val, e);
    end
  end

  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    chk(mem_addr == '0, "R1", "counter after reset", mem_addr, 0);

    // R4 set-current-address, upper high-byte bits ignored
    start_c();
    wb_chk({DEV, 1'b0}, 1'b1, "R3");
    wb_chk(8'hF9, 1'b1, "R4");
    wb_chk(8'h23, 1'b1, "R4");
    stop_c();
    chk(mem_addr == 11'h123, "R4", "counter after STOP", mem_addr, 11'h123);
    chk(sda_oe == 1'b0, "R9", "released after STOP", sda_oe, 0);

    // R5 current-address read
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R3");
    expect_byte(11'h123, "R5");
    rb(1'b0);
    stop_c();

    // R6/R7 random read with sequential wrap
    start_c();
    wb_chk({DEV, 1'b0}, 1'b1, "R3");
    wb_chk(8'h07, 1'b1, "R4");
    wb_chk(8'hFE, 1'b1, "R4");
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R5");
    expect_byte(11'h7FE, "R6");
    expect_byte(11'h7FF, "R6");
    expect_byte(11'h000, "R7");
    expect_byte(11'h001, "R7");
    rb(1'b1); rb(1'b1); rb(1'b1); rb(1'b0);
    stop_c();
    chk(mem_addr == 11'h001, "R8", "counter after NACK", mem_addr, 11'h001);

    // R8 current read repeats the last byte after NACK
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R8");
    expect_byte(11'h001, "R8");
    rb(1'b0);
    stop_c();

    // R8 STOP in the acknowledge slot
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R8");
    expect_byte(11'h001, "R8");
    rb_stop_in_ack();
    tick(10);
    chk(sda_oe == 1'b0, "R8", "released after STOP in ack slot", sda_oe, 0);
    chk(mem_addr == 11'h001, "R8", "no step on STOP in ack slot", mem_addr, 11'h001);

    // R3 mismatch
    start_c();
    wb_chk({7'h51, 1'b1}, 1'b0, "R3");
    wb_chk(8'h00, 1'b0, "R3");
    stop_c();

    // R9 bits without START
    scl = 1'b0; tick(10);
    wb_chk({DEV, 1'b1}, 1'b0, "R9");
    wb_chk(8'h00, 1'b0, "R9");
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R9");
    expect_byte(11'h001, "R9");
    rb(1'b0);
    stop_c();

    // R2 restart part way through a byte
    start_c();
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    start_c();
    wb_chk({DEV, 1'b0}, 1'b1, "R2");
    wb_chk(8'h00, 1'b1, "R2");
    wb_chk(8'h05, 1'b1, "R2");
    start_c();
    wb_chk({DEV, 1'b1}, 1'b1, "R2");
    expect_byte(11'h005, "R2");
    expect_byte(11'h006, "R6");
    rb(1'b1); rb(1'b0);
    stop_c();

    tick(20);
    chk(exp_q.size() == 0, "R5", "pending expected bytes", exp_q.size(), 0);
    chk(viol == 0, "R10", "sda_oe changes with clock high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule